// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides, cycle by cycle, whether an 8-bit timer may advance. A 3-bit source code is held in a small write-only register that the host loads. The code chooses one of several sources. One code stops the timer. One lets it run at the full system clock rate. Four codes use divided rates taken from a free-running 10-bit divider. The last two follow a chosen edge of an external count pin. The result is `cnt_en`, a strobe that lasts one system clock for each step. A `stopped` flag is also provided, so the host can tell that the timer is parked.

The external pin is sampled by a two-stage synchroniser. A two-state machine then tracks the synchronised level. Its states are `EXT_LOW` and `EXT_HIGH`:
- `EXT_LOW` moves to `EXT_HIGH` when a high level is seen. This transition is the rise event.
- `EXT_HIGH` moves to `EXT_LOW` when a low level is seen. This transition is the fall event.
- Each state stays where it is while the level does not change.

The pin is always watched, whatever drives it. Software that toggles the pin therefore advances the timer in the external modes. Writing a new code never restarts the divider.

Top module: `timer_clk_select`

## Requirements
- R1: While reset is held and just after it, `cnt_en` is 0, `stopped` is 1 and `sel_q` reads 0.
- R2: With code 0, `cnt_en` stays 0 and `stopped` is 1. Every nonzero code clears `stopped`.
- R3: With code 1, `cnt_en` is 1 in every cycle that follows a cycle in which code 1 was held.
- R4: The divider is 10 bits wide, is 0 after reset and increments on every clock. Codes 2, 3, 4 and 5 raise `cnt_en` for one cycle after each cycle in which the low 3, 6, 8 or 10 divider bits are all ones. This gives division by 8, 64, 256 and 1024.
- R5: With code 6, a falling edge of `ext_pin` produces one `cnt_en` pulse. The pulse appears right after the third rising clock edge that sees the new pin level.
- R6: With code 7, a rising edge of `ext_pin` produces one `cnt_en` pulse, with the same latency as R5.
- R7: In codes 0 to 5, activity on `ext_pin` has no effect on `cnt_en`.
- R8: A new code governs `cnt_en` from the clock after it is written. The divider phase is kept across writes.
- R9: A cycle with `sel_wr` high loads `sel_wdata` into the register. `sel_q` shows the new code after that clock.
- R10: In every code except 1, each `cnt_en` pulse is a single cycle long while the code is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Write strobe for the source code register |
| sel_wdata | input | 3 | Source code to load |
| ext_pin | input | 1 | External count pin, asynchronous |
| sel_q | output | 3 | Current source code |
| cnt_en | output | 1 | One-cycle count-enable strobe for the timer |
| stopped | output | 1 | High while the source code is 0 |

## Verification
Every code is driven in turn, and a bench model predicts `cnt_en` and `stopped` on every cycle.

The divided codes run long enough to show at least two pulses each. This separates the four tap widths from one another and from an off-by-one divider phase.

The pin is toggled in code 0, in a divided code and in both edge codes. Together these runs show:
- only the selected edge counts;
- the latency is exactly three clocks;
- the pin is ignored elsewhere.

A mid-run change between divided codes, with no reset in between, shows that the divider phase survives a write.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int DIV_W   = 10;
    localparam int N_TAPS  = 4;
    localparam int SEL_W   = 3;
    localparam int SYNC_N  = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } src_sel_e;

    typedef enum logic {
        EXT_LOW  = 1'b0,
        EXT_HIGH = 1'b1
    } ext_state_e;

    // number of low divider bits that must be all ones for tap i
    function automatic int tap_width(input int i);
        int w;
        case (i)
            0:       w = 3;
            1:       w = 6;
            2:       w = 8;
            default: w = 10;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
    parameter int DIV_W  = tcs_pkg::DIV_W,
    parameter int N_TAPS = tcs_pkg::N_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_TAPS-1:0] tap_hit
);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int TW = tcs_pkg::tap_width(i);
        assign tap_hit[i] = &div_q[TW-1:0];
    end

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge #(
    parameter int SYNC_N = tcs_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise_p,
    output logic fall_p
);
    import tcs_pkg::*;

    logic [SYNC_N-1:0] sync_q;
    logic              pin_lvl;
    ext_state_e        state_q;
    ext_state_e        state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin};
        end
    end

    assign pin_lvl = sync_q[SYNC_N-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EXT_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_LOW:  if (pin_lvl)  state_d = EXT_HIGH;
            EXT_HIGH: if (!pin_lvl) state_d = EXT_LOW;
        endcase
    end

    // outputs: one pulse per transition
    always_comb begin
        rise_p = 1'b0;
        fall_p = 1'b0;
        unique case (state_q)
            EXT_LOW:  rise_p = pin_lvl;
            EXT_HIGH: fall_p = !pin_lvl;
        endcase
    end

endmodule

// File: rtl/tcs_enable_mux.sv
module tcs_enable_mux #(
    parameter int N_TAPS = tcs_pkg::N_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tcs_pkg::src_sel_e sel,
    input  logic [N_TAPS-1:0] tap_hit,
    input  logic              rise_p,
    input  logic              fall_p,
    output logic              cnt_en
);
    import tcs_pkg::*;

    logic en_d;

    always_comb begin
        en_d = 1'b0;
        unique case (sel)
            SRC_OFF:      en_d = 1'b0;
            SRC_SYS:      en_d = 1'b1;
            SRC_DIV8:     en_d = tap_hit[0];
            SRC_DIV64:    en_d = tap_hit[1];
            SRC_DIV256:   en_d = tap_hit[2];
            SRC_DIV1024:  en_d = tap_hit[3];
            SRC_PIN_FALL: en_d = fall_p;
            SRC_PIN_RISE: en_d = rise_p;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en <= 1'b0;
        end else begin
            cnt_en <= en_d;
        end
    end

endmodule

// File: rtl/timer_clk_select.sv
module timer_clk_select #(
    parameter int DIV_W  = tcs_pkg::DIV_W,
    parameter int N_TAPS = tcs_pkg::N_TAPS,
    parameter int SYNC_N = tcs_pkg::SYNC_N
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [2:0] sel_wdata,
    input  logic       ext_pin,
    output logic [2:0] sel_q,
    output logic       cnt_en,
    output logic       stopped
);
    import tcs_pkg::*;

    src_sel_e          sel_r;
    logic [N_TAPS-1:0] tap_hit;
    logic              rise_p;
    logic              fall_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_r <= SRC_OFF;
        end else if (sel_wr) begin
            sel_r <= src_sel_e'(sel_wdata);
        end
    end

    assign sel_q   = sel_r;
    assign stopped = (sel_r == SRC_OFF);

    tcs_prescaler #(.DIV_W(DIV_W), .N_TAPS(N_TAPS)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_hit (tap_hit)
    );

    tcs_pin_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (ext_pin),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    tcs_enable_mux #(.N_TAPS(N_TAPS)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_r),
        .tap_hit (tap_hit),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .cnt_en  (cnt_en)
    );

endmodule

// File: rtl/timer_clk_select_chk.sv
module timer_clk_select_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_wr,
    input logic [2:0] sel_wdata,
    input logic [2:0] sel_q,
    input logic       cnt_en,
    input logic       stopped
);

    // R2
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stopped) |-> !cnt_en);

    // R3
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_q) == 3'd1) |-> cnt_en);

    // R9
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_q == $past(sel_wdata)));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && sel_q != 3'd1 && sel_q == $past(sel_q)) |=> !cnt_en);

endmodule

bind timer_clk_select timer_clk_select_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .sel_q     (sel_q),
    .cnt_en    (cnt_en),
    .stopped   (stopped)
);

// File: tb/timer_clk_select_bench.sv
module timer_clk_select_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = 3'd0;
    logic       ext_pin = 1'b0;
    logic [2:0] sel_q;
    logic       cnt_en;
    logic       stopped;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string phase_tag = "R1";

    typedef struct {
        logic  en;
        logic  stp;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // model state
    logic [9:0] m_div;
    logic [2:0] m_sel;
    logic m_s1, m_s2, m_prev;

    always #2.5 clk = ~clk;

    timer_clk_select u_timer_clk_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .ext_pin   (ext_pin),
        .sel_q     (sel_q),
        .cnt_en    (cnt_en),
        .stopped   (stopped)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model, pushes one expected item per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = '0; m_sel = '0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            exp_t e;
            case (m_sel)
                3'd0: e.en = 1'b0;
                3'd1: e.en = 1'b1;
                3'd2: e.en = &m_div[2:0];
                3'd3: e.en = &m_div[5:0];
                3'd4: e.en = &m_div[7:0];
                3'd5: e.en = &m_div[9:0];
                3'd6: e.en = m_prev & ~m_s2;
                default: e.en = ~m_prev & m_s2;
            endcase
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = ext_pin;
            if (sel_wr) m_sel = sel_wdata;
            m_div = m_div + 1'b1;
            e.stp = (m_sel == 3'd0);
            e.tag = phase_tag;
            sb_q.push_back(e);
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " cnt_en"}, {31'd0, cnt_en}, {31'd0, e.en});
            chk({e.tag, " stopped"}, {31'd0, stopped}, {31'd0, e.stp});
        end
    end

    task automatic wr_sel(input logic [2:0] c, input string tag);
        phase_tag = tag;
        sel_wr = 1'b1;
        sel_wdata = c;
        @(negedge clk);
        sel_wr = 1'b0;
        chk("R9 sel_q", {29'd0, sel_q}, {29'd0, c});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic toggle_pin(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            ext_pin = ~ext_pin;
            idle(gap);
        end
    endtask

    initial begin
        idle(3);
        // R1: state during reset
        chk("R1 cnt_en", {31'd0, cnt_en}, 32'd0);
        chk("R1 stopped", {31'd0, stopped}, 32'd1);
        chk("R1 sel_q", {29'd0, sel_q}, 32'd0);
        rst_n = 1'b1;
        idle(20);
        wr_sel(3'd1, "R3");   idle(20);
        wr_sel(3'd2, "R4");   idle(40);
        wr_sel(3'd3, "R4");   idle(200);
        wr_sel(3'd4, "R4");   idle(600);
        wr_sel(3'd5, "R4");   idle(2200);
        // R7: pin toggling in stop and divided codes
        wr_sel(3'd0, "R7");   toggle_pin(10, 3); idle(10);
        wr_sel(3'd3, "R7");   toggle_pin(20, 7); idle(20);
        wr_sel(3'd6, "R5");   toggle_pin(12, 4); toggle_pin(6, 9); idle(10);
        wr_sel(3'd7, "R6");   toggle_pin(12, 5); toggle_pin(4, 2); idle(10);
        // R8: switch divided codes without reset, phase kept
        wr_sel(3'd2, "R8");   idle(13);
        wr_sel(3'd3, "R8");   idle(70);
        wr_sel(3'd2, "R8");   idle(5);
        wr_sel(3'd0, "R2");   idle(30);
        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule